// File: doc/BRIEF.md
# Four-Phase Strobe-Interlocked Read Link

This block joins a read-only requester and a small register-backed responder with a strobe pair that has no shared transfer clock. Each step of a read starts only when the other side's last step has been seen. The requester raises a read by pulling its request strobe low with an address already on the address lines. The responder puts the addressed word on the data lines and then pulls its acknowledge strobe low. The requester takes the word and releases its strobe. The responder then removes the data and releases the acknowledge. Only after that may the requester begin again.

Both sides are written as synchronous logic. Each side passes the other side's strobe through a two-stage synchronizer before it acts on it. The responder's response delay can be set per read from 0 to 7 cycles. The responder claims only addresses that fall inside its array. A read of any other address is left unanswered, and a watchdog in the requester ends that read with an error.

Top module: `hs_read_link`

## Requirements
- R1: While reset is held and on the first cycle after it, both strobes (`msyn_n_o`, `ssyn_n_o`) are high. `busy_o`, `done_o` and `err_o` are 0, and `rdata_o` and `bus_data_o` are 0.
- R2: When `req_i` is seen high on an edge while the requester is idle, the request strobe goes low after that edge and `busy_o` rises. `addr_i` is latched as the transfer address. A `req_i` seen while `busy_o` is high has no effect on any output.
- R3: For a claimed address a (a < 16), the responder drives the word ((a*29) XOR 0x5A) mod 256 on `bus_data_o` starting 3 cycles after the request strobe fell. Outside the window in which it drives a word, `bus_data_o` reads 0.
- R4: The acknowledge strobe falls L+1 cycles after the data first appears, where L is `lat_i` (0 to 7) as sampled at the accepting edge. The data is therefore stable for at least one full cycle before the acknowledge falls.
- R5: 3 cycles after the acknowledge falls, the requester loads the word into `rdata_o`, pulses `done_o` for one cycle and raises the request strobe, all on the same edge. `rdata_o` holds its value until the next successful read.
- R6: 3 cycles after the request strobe rises, the responder stops driving data. One cycle later it raises the acknowledge strobe.
- R7: 3 cycles after the acknowledge rises, `busy_o` falls. A new request is accepted no earlier than the following edge, so a successful read occupies 15+L cycles from one acceptance to the earliest next one.
- R8: An address of 16 or more is not claimed, and the acknowledge stays high. On the 64th edge after acceptance, `err_o` pulses for one cycle and the request strobe rises. `rdata_o` is unchanged, and `busy_o` falls on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both sides' synchronous logic |
| rst_n | input | 1 | Synchronous reset, active low |
| req_i | input | 1 | Read request, taken when the requester is idle |
| addr_i | input | 8 | Read address, latched on acceptance |
| lat_i | input | 3 | Responder delay L for the read being accepted |
| busy_o | output | 1 | A read is in progress |
| done_o | output | 1 | One-cycle pulse when read data is captured |
| err_o | output | 1 | One-cycle pulse when the watchdog expires |
| rdata_o | output | 8 | Last captured read word |
| msyn_n_o | output | 1 | Request strobe, active low |
| ssyn_n_o | output | 1 | Acknowledge strobe, active low |
| bus_data_o | output | 8 | Data lines driven by the responder, 0 when not driven |

## Verification
The requester's return to idle and the acceptance of the next request can fall on neighbouring edges. To provoke this, the bench holds `req_i` high across a whole read, so that a second read must start on the first edge after `busy_o` drops, and never earlier. The bench also pulses `req_i` with a different address in the middle of a read, and checks that the address latched for the current read and the strobe timing are not disturbed. The behavioural model predicts every strobe, data and status output from the acceptance time and L, and it is compared with the outputs on every cycle, so an acceptance one cycle early or late shows up as a miscompare.

// File: rtl/hs_pkg.sv
// Shared state encodings for the strobe-interlocked read link.
package hs_pkg;

    // Requester phases: idle, waiting for the acknowledge, waiting for the acknowledge to be released.
    typedef enum logic [1:0] {
        M_IDLE,
        M_WAIT,
        M_REL
    } mst_state_t;

    // Responder phases: idle, data driven while counting the delay, acknowledged, data withdrawn.
    typedef enum logic [1:0] {
        S_IDLE,
        S_DRIVE,
        S_ACK,
        S_DROP
    } slv_state_t;

endpackage

// File: rtl/hs_sync2.sv
// Multi-stage synchronizer for one strobe line.
// Assumes the idle level of the strobe is high; every stage resets to 1.
module hs_sync2 #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);

    logic [STAGES-1:0] sr;

    // Shift the asynchronous input through the stages.
    always_ff @(posedge clk) begin
        if (!rst_n) sr <= '1;
        else        sr <= {sr[STAGES-2:0], d_i};
    end

    assign q_o = sr[STAGES-1];

endmodule

// File: rtl/hs_master.sv
// Requester side. It accepts a read request, holds the address and the request strobe
// until the synchronized acknowledge falls, captures the data, releases the strobe, and
// waits for the acknowledge to return high. A watchdog ends an unanswered read.
// Assumes the acknowledge strobe is asynchronous to clk.
module hs_master
    import hs_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 8,
    parameter int WD_CYCLES = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              ssyn_n_i,
    input  logic [DATA_W-1:0] bus_data_i,
    output logic              msyn_n_o,
    output logic [ADDR_W-1:0] bus_addr_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_o,
    output logic [DATA_W-1:0] rdata_o
);

    localparam int WD_W = $clog2(WD_CYCLES);

    mst_state_t        state;
    logic [WD_W-1:0]   wd;
    logic              ssyn_q;

    hs_sync2 #(.STAGES(2)) u_ssyn_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d_i  (ssyn_n_i),
        .q_o  (ssyn_q)
    );

    // Requester sequence: accept, wait for the acknowledge or the timeout, wait for release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= M_IDLE;
            msyn_n_o   <= 1'b1;
            bus_addr_o <= '0;
            wd         <= '0;
            done_o     <= 1'b0;
            err_o      <= 1'b0;
            rdata_o    <= '0;
        end else begin
            done_o <= 1'b0;
            err_o  <= 1'b0;
            case (state)
                M_IDLE: begin
                    if (req_i && ssyn_q) begin
                        bus_addr_o <= addr_i;
                        msyn_n_o   <= 1'b0;
                        wd         <= '0;
                        state      <= M_WAIT;
                    end
                end
                M_WAIT: begin
                    if (!ssyn_q) begin
                        rdata_o  <= bus_data_i;
                        done_o   <= 1'b1;
                        msyn_n_o <= 1'b1;
                        state    <= M_REL;
                    end else if (wd == WD_W'(WD_CYCLES - 1)) begin
                        err_o    <= 1'b1;
                        msyn_n_o <= 1'b1;
                        state    <= M_REL;
                    end else begin
                        wd <= wd + 1'b1;
                    end
                end
                M_REL: begin
                    if (ssyn_q) state <= M_IDLE;
                end
                default: state <= M_IDLE;
            endcase
        end
    end

    assign busy_o = (state != M_IDLE);

    // The strobe is released only together with a capture or a timeout.
    assert_release_has_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(msyn_n_o) |-> (done_o || err_o));

    // A read ends with one outcome, never both.
    assert_single_outcome_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done_o, err_o}));

    // A new read starts only after the acknowledge was seen high.
    assert_start_after_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(msyn_n_o) |-> $past(ssyn_q));

    // A timeout leaves the strobe released and the captured word untouched.
    assert_timeout_keeps_data_R8: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (msyn_n_o && $stable(rdata_o)));

endmodule

// File: rtl/hs_slave.sv
// Responder side. It claims addresses inside its register array, drives the addressed
// word, waits the requested delay, pulls the acknowledge low, and withdraws the data
// before it releases the acknowledge once the request strobe has returned high.
// Assumes the request strobe is asynchronous to clk and that the address is stable
// while the request strobe is low.
module hs_slave
    import hs_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16,
    parameter int LAT_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              msyn_n_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [LAT_W-1:0]  lat_i,
    output logic              ssyn_n_o,
    output logic [DATA_W-1:0] bus_data_o
);

    localparam int IDX_W = $clog2(DEPTH);

    slv_state_t        state;
    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] data_q;
    logic              data_oe;
    logic [LAT_W-1:0]  cnt;
    logic              msyn_q;
    logic              claimed;

    hs_sync2 #(.STAGES(2)) u_msyn_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d_i  (msyn_n_i),
        .q_o  (msyn_q)
    );

    // Load the fixed array contents at reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= DATA_W'((i * 29) ^ 'h5A);
        end
    end

    assign claimed = (int'(bus_addr_i) < DEPTH);

    // Responder sequence: drive the data, count the delay, acknowledge, withdraw, release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            ssyn_n_o <= 1'b1;
            data_oe  <= 1'b0;
            data_q   <= '0;
            cnt      <= '0;
        end else begin
            case (state)
                S_IDLE: begin
                    if (!msyn_q && claimed) begin
                        data_q  <= mem[bus_addr_i[IDX_W-1:0]];
                        data_oe <= 1'b1;
                        cnt     <= lat_i;
                        state   <= S_DRIVE;
                    end
                end
                S_DRIVE: begin
                    if (cnt == '0) begin
                        ssyn_n_o <= 1'b0;
                        state    <= S_ACK;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                S_ACK: begin
                    if (msyn_q) begin
                        data_oe <= 1'b0;
                        state   <= S_DROP;
                    end
                end
                S_DROP: begin
                    ssyn_n_o <= 1'b1;
                    state    <= S_IDLE;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    assign bus_data_o = data_oe ? data_q : '0;

    // The data is already driven for at least a cycle when the acknowledge falls.
    assert_data_leads_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ssyn_n_o) |-> (data_oe && $past(data_oe)));

    // The data is withdrawn before the acknowledge is released.
    assert_data_off_before_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ssyn_n_o) |-> $past(!data_oe));

endmodule

// File: rtl/hs_read_link.sv
// Top level: one requester and one responder joined by the strobe pair, the address
// lines and the data lines. The strobes and the data lines are brought out for observation.
module hs_read_link #(
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 8,
    parameter int DEPTH     = 16,
    parameter int LAT_W     = 3,
    parameter int WD_CYCLES = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [LAT_W-1:0]  lat_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic              msyn_n_o,
    output logic              ssyn_n_o,
    output logic [DATA_W-1:0] bus_data_o
);

    logic [ADDR_W-1:0] bus_addr;
    logic [DATA_W-1:0] bus_data;
    logic              msyn_n;
    logic              ssyn_n;

    hs_master #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .WD_CYCLES(WD_CYCLES)
    ) u_master (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_i     (req_i),
        .addr_i    (addr_i),
        .ssyn_n_i  (ssyn_n),
        .bus_data_i(bus_data),
        .msyn_n_o  (msyn_n),
        .bus_addr_o(bus_addr),
        .busy_o    (busy_o),
        .done_o    (done_o),
        .err_o     (err_o),
        .rdata_o   (rdata_o)
    );

    hs_slave #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W),
        .DEPTH (DEPTH),
        .LAT_W (LAT_W)
    ) u_slave (
        .clk       (clk),
        .rst_n     (rst_n),
        .msyn_n_i  (msyn_n),
        .bus_addr_i(bus_addr),
        .lat_i     (lat_i),
        .ssyn_n_o  (ssyn_n),
        .bus_data_o(bus_data)
    );

    assign msyn_n_o   = msyn_n;
    assign ssyn_n_o   = ssyn_n;
    assign bus_data_o = bus_data;

endmodule

// File: tb/hs_read_link_bench.sv
// Bench for hs_read_link. A behavioural timeline model predicts every output from the
// acceptance edge and the delay L, and it is compared with the outputs on every cycle.
module hs_read_link_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_i = 1'b0;
    logic [7:0] addr_i = '0;
    logic [2:0] lat_i = '0;
    logic       busy_o, done_o, err_o, msyn_n_o, ssyn_n_o;
    logic [7:0] rdata_o, bus_data_o;

    int vectors = 0;
    int fails   = 0;
    int cycles  = 0;
    bit compare_on = 1'b0;

    // Model state
    bit       m_active = 1'b0;
    bit       m_valid  = 1'b0;
    int       m_t = 0, m_L = 0, m_end = 0;
    int       m_addr = 0;
    logic [7:0] m_rdata = '0;

    hs_read_link u_hs_read_link (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_i     (req_i),
        .addr_i    (addr_i),
        .lat_i     (lat_i),
        .busy_o    (busy_o),
        .done_o    (done_o),
        .err_o     (err_o),
        .rdata_o   (rdata_o),
        .msyn_n_o  (msyn_n_o),
        .ssyn_n_o  (ssyn_n_o),
        .bus_data_o(bus_data_o)
    );

    always #4 clk = ~clk;

    function automatic logic [7:0] word_at(int a);
        return 8'((a * 29) ^ 'h5A);
    endfunction

    // Timeline model, advanced on each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_active = 1'b0;
            m_t      = 0;
            m_rdata  = '0;
        end else if (m_active) begin
            m_t++;
            if (m_valid && m_t == 7 + m_L) m_rdata = word_at(m_addr);
            if (m_t == m_end) m_active = 1'b0;
        end else if (req_i) begin
            m_active = 1'b1;
            m_t      = 0;
            m_L      = int'(lat_i);
            m_addr   = int'(addr_i);
            m_valid  = (addr_i < 8'd16);
            m_end    = m_valid ? 14 + m_L : 65;
        end
    end

    task automatic chk(string tag, string what, int act, int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s at cycle %0d: actual %0h expected %0h", tag, what, cycles, act, exp);
        end
    endtask

    // Compare all outputs with the model away from the rising edge.
    always @(negedge clk) begin
        cycles++;
        if (compare_on) begin
            bit vw;
            int e_msyn, e_ssyn, e_data, e_done, e_err, e_busy;
            vw     = m_active && m_valid;
            e_msyn = (m_active && (m_valid ? (m_t <= 6 + m_L) : (m_t <= 63))) ? 0 : 1;
            e_ssyn = (vw && m_t >= 4 + m_L && m_t <= 10 + m_L) ? 0 : 1;
            e_data = (vw && m_t >= 3 && m_t <= 9 + m_L) ? int'(word_at(m_addr)) : 0;
            e_done = (vw && m_t == 7 + m_L) ? 1 : 0;
            e_err  = (m_active && !m_valid && m_t == 64) ? 1 : 0;
            e_busy = m_active ? 1 : 0;
            chk("R2", "msyn_n", int'(msyn_n_o), e_msyn);
            chk("R4", "ssyn_n", int'(ssyn_n_o), e_ssyn);
            chk("R3", "bus_data", int'(bus_data_o), e_data);
            chk("R5", "done", int'(done_o), e_done);
            chk("R5", "rdata", int'(rdata_o), int'(m_rdata));
            chk("R7", "busy", int'(busy_o), e_busy);
            chk("R8", "err", int'(err_o), e_err);
        end
    end

    // Watchdog: a hung run is reported as a failed check.
    always @(negedge clk) begin
        if (cycles > 20000) begin
            fails++;
            $display("FAIL watchdog: run did not finish, actual %0d cycles expected under 20000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    task automatic wait_idle();
        @(negedge clk);
        while (m_active) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic read_one(int a, int l);
        addr_i = 8'(a);
        lat_i  = 3'(l);
        req_i  = 1'b1;
        @(negedge clk);
        req_i  = 1'b0;
        wait_idle();
    endtask

    initial begin
        // R1: reset values while reset is held
        repeat (3) @(negedge clk);
        chk("R1", "msyn_n", int'(msyn_n_o), 1);
        chk("R1", "ssyn_n", int'(ssyn_n_o), 1);
        chk("R1", "busy", int'(busy_o), 0);
        chk("R1", "rdata", int'(rdata_o), 0);
        chk("R1", "bus_data", int'(bus_data_o), 0);
        compare_on = 1'b1;
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R3 R4 R5 R6 R7: plain reads at the latency extremes and in between
        read_one(5, 0);
        read_one(15, 7);
        read_one(0, 3);
        read_one(10, 1);

        // R2: a request pulsed mid-read with another address must be ignored
        addr_i = 8'd7; lat_i = 3'd4; req_i = 1'b1;
        @(negedge clk);
        req_i = 1'b0;
        repeat (5) @(negedge clk);
        addr_i = 8'd12; req_i = 1'b1;
        @(negedge clk);
        req_i = 1'b0;
        wait_idle();

        // R7: request held high, the second read starts on the first idle edge
        addr_i = 8'd9; lat_i = 3'd2; req_i = 1'b1;
        repeat (2 * 17 + 3) @(negedge clk);
        req_i = 1'b0;
        wait_idle();

        // R8: unclaimed address runs into the watchdog, rdata untouched
        read_one(200, 1);
        read_one(16, 0);

        // R8: recovery after a timeout
        read_one(3, 5);

        // R1: reset in the middle of a read returns everything to idle
        addr_i = 8'd6; lat_i = 3'd6; req_i = 1'b1;
        @(negedge clk);
        req_i = 1'b0;
        repeat (8) @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        read_one(14, 2);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule